// File: doc/BRIEF.md
# Dual-Destination Integer Execution Unit

This unit executes one integer group in which every operation names up to four general registers. It receives an 8-bit sub-opcode and the current contents of the source registers b, c and d. One clock later it presents up to three register writes: destination a, destination b and destination d. Each write has its own enable. Carry and borrow move through an ordinary register and not through a flag bit. A carry-in is read from d and counts as one whenever d is nonzero. A carry-out or borrow-out is written back into d as the value 1 or 0. One operation can therefore update two registers in the same cycle. Sort does this with its maximum and minimum, and the carry-out forms do it with a sum and its carry.

The supported operations are add and subtract, each with carry or borrow in, out, or both, and each in a signed and an unsigned variant. There are also two bitwise selects that take their per-bit choice from b, and a sort that returns both the larger and the smaller of c and d. Register a is only ever a destination, so its old value is not an input. The long-math sub-opcodes, multiply and divide, raise an unsupported flag. Every sub-opcode above the sort pair raises a reserved flag. Neither case writes any register. The register width is a parameter. Another parameter chooses between a single shared adder-subtractor and two separate datapaths.

Top module: `quad_int_exec`

## Requirements
- R1: While reset is active, and in the first cycle after it, `out_valid`, all three write enables, `reserved_op` and `unsupported_op` are low.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, one clock later, in order. A cycle without `in_valid` produces no result and no write enable.
- R3: Sub-opcode 0x00 (signed) and 0x03 (unsigned) write a = b + c + k modulo 2^W. Here k is 1 when d is nonzero and 0 otherwise. Only the a write is enabled.
- R4: Sub-opcode 0x01 (signed) and 0x04 (unsigned) write a = b + c and write d as 0 or 1. For 0x01, d is 1 when the signed sum overflows W bits. For 0x04, d is 1 when the sum carries out of bit W-1. Writes a and d are enabled.
- R5: Sub-opcode 0x02 (signed) and 0x05 (unsigned) take their carry-in from the incoming d, as in R3. They write the new carry of the full three-term sum into d, as in R4. Writes a and d are enabled.
- R6: Sub-opcodes 0x06 to 0x0B are the subtract forms, ordered as borrow-in, borrow-out and both, signed first (0x06 to 0x08) and then unsigned (0x09 to 0x0B). They write a = b - c - k. A signed borrow-out is overflow of that difference. An unsigned borrow-out is 1 exactly when b < c + k.
- R7: Sub-opcode 0x10 writes a = (c & ~b) | (d & b). Sub-opcode 0x11 writes a = (c & b) | (d & ~b). Only the a write is enabled.
- R8: Sub-opcode 0x12 writes the signed maximum of c and d into a and the signed minimum into b. Sub-opcode 0x13 does the same with an unsigned comparison. Writes a and b are enabled.
- R9: Sub-opcodes 0x0C to 0x0F raise `unsupported_op` with the result. No write enable is raised and `reserved_op` stays low.
- R10: Sub-opcodes 0x14 to 0xFF raise `reserved_op` with the result. No write enable is raised and `unsupported_op` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operation on the inputs is to be executed |
| sub_op | input | 8 | Sub-opcode selecting the operation |
| opnd_b | input | W | Contents of register b |
| opnd_c | input | W | Contents of register c |
| opnd_d | input | W | Contents of register d (carry or borrow source) |
| out_valid | output | 1 | A result is present this cycle |
| wr_a_en | output | 1 | Write enable for destination a |
| wr_a_data | output | W | Value for destination a |
| wr_b_en | output | 1 | Write enable for destination b |
| wr_b_data | output | W | Value for destination b |
| wr_d_en | output | 1 | Write enable for destination d |
| wr_d_data | output | W | Value for destination d (0 or 1) |
| reserved_op | output | 1 | The sub-opcode lies in the reserved range |
| unsupported_op | output | 1 | The sub-opcode is a multiply or divide form |

## Verification
In the combined forms, register d is read as a carry or borrow source and written as a carry or borrow destination in the same operation. The new value must come from the full three-term result and not from b ± c alone. The bench provokes this with 0x02, 0x05, 0x08 and 0x0B at boundaries where only the extra carry-in tips the result over the edge. It uses incoming d values other than 1 to show that any nonzero value counts as one. A scoreboard judges the a and d writes of each result together against the expected pair. Sort's double write of a and b is judged the same way, with operands whose signed and unsigned order disagree.

// File: rtl/qx_pkg.sv
package qx_pkg;

   typedef enum logic [2:0] {
      QK_IDLE,
      QK_ARITH,
      QK_SEL,
      QK_SELN,
      QK_SORT
   } qx_kind_e;

   typedef struct packed {
      qx_kind_e kind;
      logic     is_sub;
      logic     is_signed;
      logic     use_cin;
      logic     wants_a;
      logic     wants_b;
      logic     wants_d;
      logic     unsup;
      logic     rsvd;
   } qx_ctl_t;

   localparam logic [7:0] QX_ARITH_LAST = 8'h0B;
   localparam logic [7:0] QX_SUB_FIRST  = 8'h06;
   localparam logic [7:0] QX_LONG_LAST  = 8'h0F;
   localparam logic [7:0] QX_OP_SEL     = 8'h10;
   localparam logic [7:0] QX_OP_SELN    = 8'h11;
   localparam logic [7:0] QX_OP_SORT_S  = 8'h12;
   localparam logic [7:0] QX_OP_SORT_U  = 8'h13;
   localparam logic [7:0] QX_FORMS      = 8'd3;

endpackage

// File: rtl/qx_decode.sv
module qx_decode
   import qx_pkg::*;
(
   input  logic [7:0] sub_op,
   output qx_ctl_t    ctl
);

   logic [7:0] grp;
   logic [7:0] form;

   always_comb begin
      ctl      = '0;
      ctl.kind = QK_IDLE;
      grp      = '0;
      form     = '0;
      if (sub_op <= QX_ARITH_LAST) begin
         ctl.kind      = QK_ARITH;
         ctl.is_sub    = (sub_op >= QX_SUB_FIRST);
         grp           = ctl.is_sub ? (sub_op - QX_SUB_FIRST) : sub_op;
         ctl.is_signed = (grp < QX_FORMS);
         form          = ctl.is_signed ? grp : (grp - QX_FORMS);
         ctl.use_cin   = (form != 8'd1);
         ctl.wants_a   = 1'b1;
         ctl.wants_d   = (form != 8'd0);
      end else if (sub_op <= QX_LONG_LAST) begin
         ctl.unsup = 1'b1;
      end else if (sub_op == QX_OP_SEL) begin
         ctl.kind    = QK_SEL;
         ctl.wants_a = 1'b1;
      end else if (sub_op == QX_OP_SELN) begin
         ctl.kind    = QK_SELN;
         ctl.wants_a = 1'b1;
      end else if (sub_op == QX_OP_SORT_S || sub_op == QX_OP_SORT_U) begin
         ctl.kind      = QK_SORT;
         ctl.is_signed = (sub_op == QX_OP_SORT_S);
         ctl.wants_a   = 1'b1;
         ctl.wants_b   = 1'b1;
      end else begin
         ctl.rsvd = 1'b1;
      end
   end

endmodule

// File: rtl/qx_addsub.sv
module qx_addsub #(
   parameter int W      = 32,
   parameter bit SHARED = 1'b1
) (
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  logic         cin,
   input  logic         is_sub,
   input  logic         is_signed,
   output logic [W-1:0] res,
   output logic         flag
);

   localparam int XW = W + 1;

   generate
      if (SHARED) begin : g_shared
         logic [W-1:0]  y;
         logic          c0;
         logic [XW-1:0] su;
         logic [XW-1:0] ss;

         assign y   = is_sub ? ~c : c;
         assign c0  = is_sub ? ~cin : cin;
         assign su  = {1'b0, b} + {1'b0, y} + {{W{1'b0}}, c0};
         assign ss  = {b[W-1], b} + {y[W-1], y} + {{W{1'b0}}, c0};
         assign res = su[W-1:0];
         always_comb begin
            if (is_signed)   flag = ss[W] ^ ss[W-1];
            else if (is_sub) flag = ~su[W];
            else             flag = su[W];
         end
      end else begin : g_split
         logic [XW-1:0] add_u;
         logic [XW-1:0] add_s;
         logic [XW-1:0] sub_u;
         logic [XW-1:0] sub_s;
         logic [XW-1:0] k;

         assign k     = {{W{1'b0}}, cin};
         assign add_u = {1'b0, b} + {1'b0, c} + k;
         assign add_s = {b[W-1], b} + {c[W-1], c} + k;
         assign sub_u = {1'b0, b} - {1'b0, c} - k;
         assign sub_s = {b[W-1], b} - {c[W-1], c} - k;
         assign res   = is_sub ? sub_u[W-1:0] : add_u[W-1:0];
         always_comb begin
            case ({is_sub, is_signed})
               2'b00:   flag = add_u[W];
               2'b01:   flag = add_s[W] ^ add_s[W-1];
               2'b10:   flag = sub_u[W];
               default: flag = sub_s[W] ^ sub_s[W-1];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/qx_selsort.sv
module qx_selsort
   import qx_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  logic [W-1:0] d,
   input  qx_kind_e     kind,
   input  logic         is_signed,
   output logic [W-1:0] val_a,
   output logic [W-1:0] val_b
);

   logic         c_wins;
   logic [W-1:0] hi;
   logic [W-1:0] lo;

   assign c_wins = is_signed ? ($signed(c) > $signed(d)) : (c > d);
   assign hi     = c_wins ? c : d;
   assign lo     = c_wins ? d : c;

   always_comb begin
      val_b = lo;
      case (kind)
         QK_SEL:  val_a = (c & ~b) | (d & b);
         QK_SELN: val_a = (c & b) | (d & ~b);
         default: val_a = hi;
      endcase
   end

endmodule

// File: rtl/quad_int_exec.sv
module quad_int_exec
   import qx_pkg::*;
#(
   parameter int W           = 32,
   parameter bit SHARE_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [7:0]   sub_op,
   input  logic [W-1:0] opnd_b,
   input  logic [W-1:0] opnd_c,
   input  logic [W-1:0] opnd_d,
   output logic         out_valid,
   output logic         wr_a_en,
   output logic [W-1:0] wr_a_data,
   output logic         wr_b_en,
   output logic [W-1:0] wr_b_data,
   output logic         wr_d_en,
   output logic [W-1:0] wr_d_data,
   output logic         reserved_op,
   output logic         unsupported_op
);

   localparam int FLAG_PAD = W - 1;

   generate
      if (W < 2) begin : g_width_chk
         $error("quad_int_exec: W must be at least 2");
      end
   endgenerate

   qx_ctl_t      ctl;
   logic         cin;
   logic [W-1:0] arith_res;
   logic         arith_flag;
   logic [W-1:0] ss_a;
   logic [W-1:0] ss_b;
   logic [W-1:0] a_next;
   logic [W-1:0] d_next;

   qx_decode u_dec (
      .sub_op (sub_op),
      .ctl    (ctl)
   );

   assign cin = ctl.use_cin & (|opnd_d);

   qx_addsub #(.W(W), .SHARED(SHARE_ADDER)) u_as (
      .b         (opnd_b),
      .c         (opnd_c),
      .cin       (cin),
      .is_sub    (ctl.is_sub),
      .is_signed (ctl.is_signed),
      .res       (arith_res),
      .flag      (arith_flag)
   );

   qx_selsort #(.W(W)) u_ss (
      .b         (opnd_b),
      .c         (opnd_c),
      .d         (opnd_d),
      .kind      (ctl.kind),
      .is_signed (ctl.is_signed),
      .val_a     (ss_a),
      .val_b     (ss_b)
   );

   assign a_next = (ctl.kind == QK_ARITH) ? arith_res : ss_a;
   assign d_next = {{FLAG_PAD{1'b0}}, arith_flag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         wr_a_en        <= 1'b0;
         wr_b_en        <= 1'b0;
         wr_d_en        <= 1'b0;
         reserved_op    <= 1'b0;
         unsupported_op <= 1'b0;
      end else begin
         out_valid      <= in_valid;
         wr_a_en        <= in_valid & ctl.wants_a;
         wr_b_en        <= in_valid & ctl.wants_b;
         wr_d_en        <= in_valid & ctl.wants_d;
         reserved_op    <= in_valid & ctl.rsvd;
         unsupported_op <= in_valid & ctl.unsup;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_a_data <= '0;
         wr_b_data <= '0;
         wr_d_data <= '0;
      end else if (in_valid) begin
         wr_a_data <= a_next;
         wr_b_data <= ss_b;
         wr_d_data <= d_next;
      end
   end

endmodule

// File: rtl/qx_check.sv
module qx_check #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [7:0]   sub_op,
   input logic         out_valid,
   input logic         wr_a_en,
   input logic [W-1:0] wr_a_data,
   input logic         wr_b_en,
   input logic [W-1:0] wr_b_data,
   input logic         wr_d_en,
   input logic [W-1:0] wr_d_data,
   input logic         reserved_op,
   input logic         unsupported_op
);

   p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(wr_a_en || wr_b_en || wr_d_en || reserved_op || unsupported_op));

   p_unsup_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported_op |-> !(wr_a_en || wr_b_en || wr_d_en || reserved_op));

   p_reserved_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reserved_op |-> !(wr_a_en || wr_b_en || wr_d_en || unsupported_op));

   p_carry_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_d_en |-> (wr_d_data[W-1:1] == '0));

   p_sort_signed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a_en && wr_b_en && $past(sub_op) == 8'h12)
         |-> ($signed(wr_a_data) >= $signed(wr_b_data)));

   p_sort_unsigned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a_en && wr_b_en && $past(sub_op) == 8'h13) |-> (wr_a_data >= wr_b_data));

endmodule

bind quad_int_exec qx_check #(.W(W)) u_qx_check (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .sub_op         (sub_op),
   .out_valid      (out_valid),
   .wr_a_en        (wr_a_en),
   .wr_a_data      (wr_a_data),
   .wr_b_en        (wr_b_en),
   .wr_b_data      (wr_b_data),
   .wr_d_en        (wr_d_en),
   .wr_d_data      (wr_d_data),
   .reserved_op    (reserved_op),
   .unsupported_op (unsupported_op)
);

// File: tb/quad_int_exec_bench.sv
module quad_int_exec_bench;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   sub_op = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] opnd_c = '0;
   logic [W-1:0] opnd_d = '0;
   logic         out_valid;
   logic         wr_a_en;
   logic [W-1:0] wr_a_data;
   logic         wr_b_en;
   logic [W-1:0] wr_b_data;
   logic         wr_d_en;
   logic [W-1:0] wr_d_data;
   logic         reserved_op;
   logic         unsupported_op;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic         aen;
      logic [W-1:0] a;
      logic         ben;
      logic [W-1:0] b;
      logic         den;
      logic [W-1:0] d;
      logic         rsv;
      logic         uns;
      string        tag;
   } exp_t;

   exp_t sb_q[$];

   always #5 clk = ~clk;

   quad_int_exec #(.W(W)) u_quad_int_exec (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .sub_op         (sub_op),
      .opnd_b         (opnd_b),
      .opnd_c         (opnd_c),
      .opnd_d         (opnd_d),
      .out_valid      (out_valid),
      .wr_a_en        (wr_a_en),
      .wr_a_data      (wr_a_data),
      .wr_b_en        (wr_b_en),
      .wr_b_data      (wr_b_data),
      .wr_d_en        (wr_d_en),
      .wr_d_data      (wr_d_data),
      .reserved_op    (reserved_op),
      .unsupported_op (unsupported_op)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [7:0] op, input logic [W-1:0] b,
                                  input logic [W-1:0] c, input logic [W-1:0] d);
      exp_t   e;
      longint sb, sc, ub, uc, ts, tu;
      int     k, g, form;
      bit     issub, sgn, fl;
      e.aen = 0; e.a = '0; e.ben = 0; e.b = '0; e.den = 0; e.d = '0;
      e.rsv = 0; e.uns = 0; e.tag = "R10";
      sb = longint'($signed(b)); sc = longint'($signed(c));
      ub = longint'({32'd0, b}); uc = longint'({32'd0, c});
      if (op <= 8'h0B) begin
         issub = (op >= 8'h06);
         g     = issub ? int'(op) - 6 : int'(op);
         sgn   = (g < 3);
         form  = sgn ? g : g - 3;
         k     = (form != 1 && d != '0) ? 1 : 0;
         if (issub) begin
            tu = ub - uc - k;
            ts = sb - sc - k;
            fl = sgn ? (ts > 64'sd2147483647 || ts < -64'sd2147483648) : (ub < uc + k);
            e.tag = "R6";
         end else begin
            tu = ub + uc + k;
            ts = sb + sc + k;
            fl = sgn ? (ts > 64'sd2147483647 || ts < -64'sd2147483648) : (tu > 64'sd4294967295);
            e.tag = (form == 0) ? "R3" : (form == 1) ? "R4" : "R5";
         end
         e.aen = 1; e.a = tu[31:0];
         e.den = (form != 0); e.d = {31'd0, fl};
      end else if (op <= 8'h0F) begin
         e.uns = 1; e.tag = "R9";
      end else if (op == 8'h10) begin
         e.aen = 1; e.a = (c & ~b) | (d & b); e.tag = "R7";
      end else if (op == 8'h11) begin
         e.aen = 1; e.a = (c & b) | (d & ~b); e.tag = "R7";
      end else if (op == 8'h12 || op == 8'h13) begin
         e.aen = 1; e.ben = 1; e.tag = "R8";
         if (op == 8'h12 ? (sc > longint'($signed(d))) : (uc > longint'({32'd0, d}))) begin
            e.a = c; e.b = d;
         end else begin
            e.a = d; e.b = c;
         end
      end else begin
         e.rsv = 1;
      end
      return e;
   endfunction

   task automatic send(input logic [7:0] op, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d);
      @(negedge clk);
      in_valid = 1'b1; sub_op = op; opnd_b = b; opnd_c = c; opnd_d = d;
      sb_q.push_back(model(op, b, c, d));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         sub_op   = 8'hFF;
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected result", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(wr_a_en == e.aen, e.tag, "a enable", {31'd0, wr_a_en}, {31'd0, e.aen});
               if (e.aen) chk(wr_a_data == e.a, e.tag, "a data", wr_a_data, e.a);
               chk(wr_b_en == e.ben, e.tag, "b enable", {31'd0, wr_b_en}, {31'd0, e.ben});
               if (e.ben) chk(wr_b_data == e.b, e.tag, "b data", wr_b_data, e.b);
               chk(wr_d_en == e.den, e.tag, "d enable", {31'd0, wr_d_en}, {31'd0, e.den});
               if (e.den) chk(wr_d_data == e.d, e.tag, "d data", wr_d_data, e.d);
               chk(reserved_op == e.rsv, e.tag, "reserved flag",
                   {31'd0, reserved_op}, {31'd0, e.rsv});
               chk(unsupported_op == e.uns, e.tag, "unsupported flag",
                   {31'd0, unsupported_op}, {31'd0, e.uns});
            end
         end else begin
            chk(!(wr_a_en || wr_b_en || wr_d_en), "R2", "enables while idle",
                {29'd0, wr_a_en, wr_b_en, wr_d_en}, 32'd0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!(out_valid || wr_a_en || wr_b_en || wr_d_en || reserved_op || unsupported_op),
          "R1", "outputs in reset", {26'd0, out_valid, wr_a_en, wr_b_en, wr_d_en,
          reserved_op, unsupported_op}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!(out_valid || wr_a_en || wr_b_en || wr_d_en || reserved_op || unsupported_op),
          "R1", "outputs after reset", {26'd0, out_valid, wr_a_en, wr_b_en, wr_d_en,
          reserved_op, unsupported_op}, 32'd0);

      // R3 carry-in forms: any nonzero d counts as one
      send(8'h00, 32'd10, 32'd20, 32'd0);
      send(8'h00, 32'd10, 32'd20, 32'h8000_0000);
      send(8'h03, 32'hFFFF_FFFF, 32'd0, 32'd5);
      idle(1);
      // R4 carry-out forms at overflow edges
      send(8'h01, 32'h7FFF_FFFF, 32'd1, 32'd0);
      send(8'h01, 32'd1, 32'd2, 32'd9);
      send(8'h01, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);
      send(8'h04, 32'hFFFF_FFFF, 32'd1, 32'd0);
      send(8'h04, 32'hFFFF_FFFE, 32'd1, 32'd1);
      // R5 carry in and out on d in the same operation
      send(8'h02, 32'h7FFF_FFFF, 32'd0, 32'd7);
      send(8'h02, 32'h7FFF_FFFE, 32'd0, 32'd3);
      send(8'h05, 32'hFFFF_FFFF, 32'd0, 32'd1);
      send(8'h05, 32'hFFFF_FFFE, 32'd0, 32'h100);
      idle(2);
      // R6 subtract forms
      send(8'h06, 32'd5, 32'd3, 32'd4);
      send(8'h07, 32'h8000_0000, 32'd1, 32'd0);
      send(8'h08, 32'h8000_0001, 32'd1, 32'd2);
      send(8'h09, 32'd0, 32'd0, 32'd1);
      send(8'h0A, 32'd0, 32'd1, 32'd0);
      send(8'h0A, 32'd7, 32'd7, 32'd1);
      send(8'h0B, 32'd5, 32'd5, 32'd1);
      send(8'h0B, 32'd6, 32'd5, 32'd1);
      // R7 selects
      send(8'h10, 32'hFF00_FF00, 32'h1234_5678, 32'h9ABC_DEF0);
      send(8'h11, 32'hFF00_FF00, 32'h1234_5678, 32'h9ABC_DEF0);
      // R8 sorts where signed and unsigned order disagree
      send(8'h12, 32'd0, 32'hFFFF_FFFF, 32'd1);
      send(8'h13, 32'd0, 32'hFFFF_FFFF, 32'd1);
      send(8'h12, 32'd0, 32'd4, 32'd4);
      // R9 unsupported and R10 reserved
      send(8'h0C, 32'd1, 32'd2, 32'd3);
      send(8'h0F, 32'd1, 32'd2, 32'd3);
      send(8'h14, 32'd1, 32'd2, 32'd3);
      send(8'hFF, 32'd1, 32'd2, 32'd3);
      idle(3);

      for (int i = 0; i < 400; i++) begin
         logic [7:0]   op;
         logic [W-1:0] rb, rc, rd;
         op = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 19));
         rb = $urandom; rc = $urandom; rd = $urandom;
         if ($urandom_range(0, 3) == 0) rd = 32'($urandom_range(0, 2));
         if ($urandom_range(0, 5) == 0) rb = 32'h7FFF_FFFF;
         if ($urandom_range(0, 5) == 0) rc = 32'hFFFF_FFFF;
         send(op, rb, rc, rd);
         if ($urandom_range(0, 4) == 0) idle(1);
      end
      idle(4);
      chk(sb_q.size() == 0, "R2", "results left pending", 32'(sb_q.size()), 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule